// File: doc/BRIEF.md
# Tiered Reset Distribution Controller

This block gathers every reset request in a small switch-class chip and turns them into one reset line per sub-module domain. The lines cover the host bus interface, the host MAC, the lower and upper halves of the system register space, the remaining digital logic, two physical PHYs and one virtual PHY. The requests fall into three tiers. A chip-level reset, from the power-on input or the external reset pin, takes every domain down. A multi-module reset, either the digital reset or the soft reset, takes a fixed group of domains down. The digital reset never touches the PHYs. A single-module reset takes down exactly one PHY.

The two asynchronous reset inputs are merged and then synchronised to the 25 MHz reference clock. Assertion is immediate and release is synchronous. Each request from a register write starts a pulse of fixed length. While that pulse runs, the request bit reads back as 1, and it clears itself when the pulse ends. A register that lives inside a domain currently held in reset ignores writes. A repeated request from a register that is still live restarts its pulse. All reset outputs are active high.

Top module: `rst_tree_ctrl`

## Requirements
- R1: While the power-on input or the external pin is low, all eight reset outputs are high, with no wait for a clock edge, and all pulses are cleared. After both inputs are high, the outputs fall on the SYNC_STAGES-th rising clock edge (2 by default).
- R2: A control write with data bit 0 set (digital reset) raises the host bus interface, host MAC, lower CSR, upper CSR and digital outputs from the next edge, for PULSE_LEN cycles. The three PHY outputs stay low.
- R3: A configuration write with its data bit set (soft reset) raises only the host bus interface, host MAC and lower CSR outputs, for PULSE_LEN cycles. The upper CSR, digital and PHY outputs stay low.
- R4: A control write with data bit 1 set, or a strobe of the PHY 1 control self-clearing bit, raises only the PHY 1 output, for PULSE_LEN cycles.
- R5: A control write with data bit 2 set, or a strobe of the PHY 2 control self-clearing bit, raises only the PHY 2 output, for PULSE_LEN cycles.
- R6: A control write with data bit 3 set, a power-management virtual-PHY strobe, or a strobe of the virtual PHY control self-clearing bit raises only the virtual PHY output, for PULSE_LEN cycles.
- R7: The readback `rctl_rdata_o` shows bit 0 = digital, bit 1 = PHY 1, bit 2 = PHY 2 and bit 3 = virtual PHY pulse active. `hcfg_soft_o` shows the soft pulse. Each reads 1 exactly while its pulse runs and 0 once it ends.
- R8: A control write for a PHY whose pulse is already running reloads that pulse, so the output stays high for PULSE_LEN cycles after the latest request.
- R9: Control writes are ignored while the upper CSR output is high. Configuration writes and power-management strobes are ignored while the lower CSR output is high. Each PHY control strobe is ignored while that PHY's own output is high.
- R10: When pulses from several tiers overlap, each output is the OR of every tier that covers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 25 MHz reference clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| rctl_wr_i | input | 1 | Write strobe of the reset control register |
| rctl_wdata_i | input | 4 | Control write data: [0] digital, [1] PHY 1, [2] PHY 2, [3] virtual PHY |
| hcfg_wr_i | input | 1 | Write strobe of the hardware configuration register |
| hcfg_wdata_i | input | 1 | Soft reset request bit of the configuration write |
| pm_vphy_req_i | input | 1 | Power-management virtual PHY reset strobe |
| phy1_ctl_rst_i | input | 1 | PHY 1 control self-clearing reset strobe |
| phy2_ctl_rst_i | input | 1 | PHY 2 control self-clearing reset strobe |
| vphy_ctl_rst_i | input | 1 | Virtual PHY control self-clearing reset strobe |
| rctl_rdata_o | output | 4 | Readback of the control request bits |
| hcfg_soft_o | output | 1 | Readback of the soft reset request bit |
| rst_hbi_o | output | 1 | Host bus interface reset |
| rst_hmac_o | output | 1 | Host MAC reset |
| rst_csr_lo_o | output | 1 | Lower system register space reset |
| rst_csr_hi_o | output | 1 | Upper system register space reset |
| rst_dig_o | output | 1 | Reset of the remaining digital sub-modules |
| rst_phy1_o | output | 1 | PHY 1 reset |
| rst_phy2_o | output | 1 | PHY 2 reset |
| rst_vphy_o | output | 1 | Virtual PHY reset |

## Verification
The bench builds the controller with PULSE_LEN set to 5 and the default two-stage synchroniser. With pulses this short, a pulse can be reloaded, and pulses from two tiers can overlap and end in a staggered order, all inside a few dozen cycles. The synchroniser depth of two fixes the release of the asynchronous reset inputs at the second edge. A behavioural model of the tiers and their pulse counts is compared against every output on every clock, and directed checks sample the first and last cycle of each pulse.

// File: rtl/rst_tree_pkg.sv
package rst_tree_pkg;

  localparam int NUM_TMR = 5;
  localparam int TMR_DIG  = 0;
  localparam int TMR_SOFT = 1;
  localparam int TMR_P1   = 2;
  localparam int TMR_P2   = 3;
  localparam int TMR_VP   = 4;

  localparam int RCTL_W       = 4;
  localparam int RCTL_DIG_BIT = 0;
  localparam int RCTL_P1_BIT  = 1;
  localparam int RCTL_P2_BIT  = 2;
  localparam int RCTL_VP_BIT  = 3;

  typedef struct packed {
    logic hbi;
    logic hmac;
    logic csr_lo;
    logic csr_hi;
    logic dig;
    logic phy1;
    logic phy2;
    logic vphy;
  } rst_bus_t;

  // Tier coverage: which active pulse reaches which domain.
  function automatic rst_bus_t map_resets(input logic chip,
                                          input logic [NUM_TMR-1:0] busy);
    rst_bus_t r;
    logic multi_lo;
    logic multi_hi;
    multi_lo = busy[TMR_DIG] | busy[TMR_SOFT];
    multi_hi = busy[TMR_DIG];
    r.hbi    = chip | multi_lo;
    r.hmac   = chip | multi_lo;
    r.csr_lo = chip | multi_lo;
    r.csr_hi = chip | multi_hi;
    r.dig    = chip | multi_hi;
    r.phy1   = chip | busy[TMR_P1];
    r.phy2   = chip | busy[TMR_P2];
    r.vphy   = chip | busy[TMR_VP];
    return r;
  endfunction

endpackage

// File: rtl/rst_tree_sync.sv
module rst_tree_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic srst_n_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain <= '0;
    else           chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n_o = chain[STAGES-1];
endmodule

// File: rtl/rst_tree_pulse.sv
module rst_tree_pulse #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic req_i,
  output logic busy_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] remain;

  function automatic logic [CW-1:0] next_remain(input logic [CW-1:0] cur,
                                                input logic req);
    if (req)            return LOAD;
    else if (cur != '0) return cur - 1'b1;
    else                return '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) remain <= '0;
    else          remain <= next_remain(remain, req_i);
  end

  assign busy_o = (remain != '0);
endmodule

// File: rtl/rst_tree_ctrl.sv
module rst_tree_ctrl
  import rst_tree_pkg::*;
#(
  parameter int PULSE_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              por_n_i,
  input  logic              ext_rst_n_i,
  input  logic              rctl_wr_i,
  input  logic [RCTL_W-1:0] rctl_wdata_i,
  input  logic              hcfg_wr_i,
  input  logic              hcfg_wdata_i,
  input  logic              pm_vphy_req_i,
  input  logic              phy1_ctl_rst_i,
  input  logic              phy2_ctl_rst_i,
  input  logic              vphy_ctl_rst_i,
  output logic [RCTL_W-1:0] rctl_rdata_o,
  output logic              hcfg_soft_o,
  output logic              rst_hbi_o,
  output logic              rst_hmac_o,
  output logic              rst_csr_lo_o,
  output logic              rst_csr_hi_o,
  output logic              rst_dig_o,
  output logic              rst_phy1_o,
  output logic              rst_phy2_o,
  output logic              rst_vphy_o
);

  logic               raw_n;
  logic               sync_n;
  logic               chip_evt;
  logic               rctl_live;
  logic               lo_live;
  logic [NUM_TMR-1:0] req_vec;
  logic [NUM_TMR-1:0] busy_vec;
  rst_bus_t           rst_bus;

  assign raw_n = por_n_i & ext_rst_n_i;

  rst_tree_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .arst_n_i (raw_n),
    .srst_n_o (sync_n)
  );

  assign chip_evt = ~sync_n;

  // Register writes only land in domains that are out of reset.
  assign rctl_live = rctl_wr_i & ~rst_bus.csr_hi;
  assign lo_live   = ~rst_bus.csr_lo;

  assign req_vec[TMR_DIG]  = rctl_live & rctl_wdata_i[RCTL_DIG_BIT];
  assign req_vec[TMR_SOFT] = hcfg_wr_i & hcfg_wdata_i & lo_live;
  assign req_vec[TMR_P1]   = (rctl_live & rctl_wdata_i[RCTL_P1_BIT])
                           | (phy1_ctl_rst_i & ~rst_bus.phy1);
  assign req_vec[TMR_P2]   = (rctl_live & rctl_wdata_i[RCTL_P2_BIT])
                           | (phy2_ctl_rst_i & ~rst_bus.phy2);
  assign req_vec[TMR_VP]   = (rctl_live & rctl_wdata_i[RCTL_VP_BIT])
                           | (pm_vphy_req_i & lo_live)
                           | (vphy_ctl_rst_i & ~rst_bus.vphy);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    rst_tree_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk_i   (clk_i),
      .rst_n_i (sync_n),
      .req_i   (req_vec[g]),
      .busy_o  (busy_vec[g])
    );
  end

  assign rst_bus = map_resets(chip_evt, busy_vec);

  assign rst_hbi_o    = rst_bus.hbi;
  assign rst_hmac_o   = rst_bus.hmac;
  assign rst_csr_lo_o = rst_bus.csr_lo;
  assign rst_csr_hi_o = rst_bus.csr_hi;
  assign rst_dig_o    = rst_bus.dig;
  assign rst_phy1_o   = rst_bus.phy1;
  assign rst_phy2_o   = rst_bus.phy2;
  assign rst_vphy_o   = rst_bus.vphy;

  assign rctl_rdata_o[RCTL_DIG_BIT] = busy_vec[TMR_DIG];
  assign rctl_rdata_o[RCTL_P1_BIT]  = busy_vec[TMR_P1];
  assign rctl_rdata_o[RCTL_P2_BIT]  = busy_vec[TMR_P2];
  assign rctl_rdata_o[RCTL_VP_BIT]  = busy_vec[TMR_VP];
  assign hcfg_soft_o                = busy_vec[TMR_SOFT];

endmodule

// File: rtl/rst_tree_chk.sv
module rst_tree_chk #(
  parameter int LEN = 16
) (
  input logic       clk_i,
  input logic       por_n_i,
  input logic       ext_rst_n_i,
  input logic       chip_evt,
  input logic [4:0] req_vec,
  input logic [3:0] rctl_rdata_o,
  input logic       hcfg_soft_o,
  input logic       rst_hbi_o,
  input logic       rst_hmac_o,
  input logic       rst_csr_lo_o,
  input logic       rst_csr_hi_o,
  input logic       rst_dig_o,
  input logic       rst_phy1_o,
  input logic       rst_phy2_o,
  input logic       rst_vphy_o
);
  int unsigned soft_run;
  int unsigned p1_since;

  always_ff @(posedge clk_i) begin
    soft_run <= hcfg_soft_o ? soft_run + 1 : 0;
    if (chip_evt)        p1_since <= LEN;
    else if (req_vec[2]) p1_since <= 0;
    else if (p1_since < LEN) p1_since <= p1_since + 1;
  end

  p_chip_all_r1: assert property (@(posedge clk_i)
    (!por_n_i || !ext_rst_n_i) |-> (rst_hbi_o && rst_hmac_o && rst_csr_lo_o &&
      rst_csr_hi_o && rst_dig_o && rst_phy1_o && rst_phy2_o && rst_vphy_o));

  p_dig_cover_r2: assert property (@(posedge clk_i) disable iff (chip_evt)
    req_vec[0] |=> (rst_hbi_o && rst_hmac_o && rst_csr_lo_o && rst_csr_hi_o && rst_dig_o));

  p_dig_spares_phy_r2: assert property (@(posedge clk_i) disable iff (chip_evt)
    (rctl_rdata_o[0] && !rctl_rdata_o[1]) |-> !rst_phy1_o);

  p_soft_cover_r3: assert property (@(posedge clk_i) disable iff (chip_evt)
    req_vec[1] |=> (rst_hbi_o && rst_hmac_o && rst_csr_lo_o && hcfg_soft_o));

  p_soft_spares_hi_r3: assert property (@(posedge clk_i) disable iff (chip_evt)
    (hcfg_soft_o && !rctl_rdata_o[0]) |-> (!rst_csr_hi_o && !rst_dig_o));

  p_phy1_r4: assert property (@(posedge clk_i) disable iff (chip_evt)
    req_vec[2] |=> (rst_phy1_o && rctl_rdata_o[1]));

  p_phy2_r5: assert property (@(posedge clk_i) disable iff (chip_evt)
    req_vec[3] |=> (rst_phy2_o && rctl_rdata_o[2]));

  p_vphy_r6: assert property (@(posedge clk_i) disable iff (chip_evt)
    req_vec[4] |=> (rst_vphy_o && rctl_rdata_o[3]));

  p_soft_len_r7: assert property (@(posedge clk_i) disable iff (chip_evt)
    $fell(hcfg_soft_o) |-> (soft_run == LEN));

  p_extend_r8: assert property (@(posedge clk_i) disable iff (chip_evt)
    (p1_since < LEN) |-> rst_phy1_o);

  p_soft_no_reload_r9: assert property (@(posedge clk_i) disable iff (chip_evt)
    soft_run <= LEN);

  p_or_tiers_r10: assert property (@(posedge clk_i) disable iff (chip_evt)
    (rctl_rdata_o[0] && hcfg_soft_o) |-> (rst_hbi_o && rst_csr_hi_o && rst_csr_lo_o));

endmodule

bind rst_tree_ctrl rst_tree_chk #(.LEN(PULSE_LEN)) u_chk (
  .clk_i        (clk_i),
  .por_n_i      (por_n_i),
  .ext_rst_n_i  (ext_rst_n_i),
  .chip_evt     (chip_evt),
  .req_vec      (req_vec),
  .rctl_rdata_o (rctl_rdata_o),
  .hcfg_soft_o  (hcfg_soft_o),
  .rst_hbi_o    (rst_hbi_o),
  .rst_hmac_o   (rst_hmac_o),
  .rst_csr_lo_o (rst_csr_lo_o),
  .rst_csr_hi_o (rst_csr_hi_o),
  .rst_dig_o    (rst_dig_o),
  .rst_phy1_o   (rst_phy1_o),
  .rst_phy2_o   (rst_phy2_o),
  .rst_vphy_o   (rst_vphy_o)
);

// File: tb/rst_tree_ctrl_test.sv
module rst_tree_ctrl_test;
  localparam int TB_LEN = 5;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_n = 1'b1;
  logic       rctl_wr = 1'b0;
  logic [3:0] rctl_wdata = 4'd0;
  logic       hcfg_wr = 1'b0;
  logic       hcfg_wdata = 1'b0;
  logic       pm_req = 1'b0;
  logic       p1_ctl = 1'b0;
  logic       p2_ctl = 1'b0;
  logic       vp_ctl = 1'b0;
  logic [3:0] rctl_rd;
  logic       soft_rd;
  logic       hbi, hmac, csr_lo, csr_hi, dig, p1, p2, vp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rst_tree_ctrl #(.PULSE_LEN(TB_LEN), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .por_n_i(por_n), .ext_rst_n_i(ext_n),
    .rctl_wr_i(rctl_wr), .rctl_wdata_i(rctl_wdata),
    .hcfg_wr_i(hcfg_wr), .hcfg_wdata_i(hcfg_wdata),
    .pm_vphy_req_i(pm_req), .phy1_ctl_rst_i(p1_ctl),
    .phy2_ctl_rst_i(p2_ctl), .vphy_ctl_rst_i(vp_ctl),
    .rctl_rdata_o(rctl_rd), .hcfg_soft_o(soft_rd),
    .rst_hbi_o(hbi), .rst_hmac_o(hmac), .rst_csr_lo_o(csr_lo),
    .rst_csr_hi_o(csr_hi), .rst_dig_o(dig), .rst_phy1_o(p1),
    .rst_phy2_o(p2), .rst_vphy_o(vp)
  );

  wire [7:0] outs = {hbi, hmac, csr_lo, csr_hi, dig, p1, p2, vp};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int  m_left[5];            // 0 digital, 1 soft, 2 phy1, 3 phy2, 4 vphy
  bit  m_q[$];               // synchroniser stages, index 0 first
  initial begin
    for (int i = 0; i < 5; i++) m_left[i] = 0;
    m_q = '{0, 0};
  end

  function automatic logic [7:0] m_outs();
    bit c, lo, hi;
    c  = !m_q[1];
    lo = c || m_left[0] > 0 || m_left[1] > 0;
    hi = c || m_left[0] > 0;
    return {lo, lo, lo, hi, hi, c || m_left[2] > 0, c || m_left[3] > 0, c || m_left[4] > 0};
  endfunction

  function automatic logic [3:0] m_rctl();
    return {m_left[4] > 0, m_left[3] > 0, m_left[2] > 0, m_left[0] > 0};
  endfunction

  always @(posedge clk) begin
    logic [7:0] o;
    bit want[5];
    bit raw, held;
    o = m_outs();
    want[0] = rctl_wr && rctl_wdata[0] && !o[4];
    want[1] = hcfg_wr && hcfg_wdata && !o[5];
    want[2] = (rctl_wr && rctl_wdata[1] && !o[4]) || (p1_ctl && !o[2]);
    want[3] = (rctl_wr && rctl_wdata[2] && !o[4]) || (p2_ctl && !o[1]);
    want[4] = (rctl_wr && rctl_wdata[3] && !o[4]) || (pm_req && !o[5]) || (vp_ctl && !o[0]);
    raw  = por_n && ext_n;
    held = !raw || !m_q[1];
    for (int i = 0; i < 5; i++) begin
      if (held)          m_left[i] = 0;
      else if (want[i])  m_left[i] = TB_LEN;
      else if (m_left[i] > 0) m_left[i] = m_left[i] - 1;
    end
    if (!raw) m_q = '{0, 0};
    else      m_q = '{1, m_q[0]};
    #2;
    chk("R10 outputs vs model", 32'(outs), 32'(m_outs()));
    chk("R7 readback vs model", 32'({soft_rd, rctl_rd}), 32'({m_left[1] > 0, m_rctl()}));
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rctl_write(input logic [3:0] v);
    rctl_wr = 1'b1; rctl_wdata = v;
    @(negedge clk);
    rctl_wr = 1'b0; rctl_wdata = 4'd0;
  endtask

  task automatic hcfg_write();
    hcfg_wr = 1'b1; hcfg_wdata = 1'b1;
    @(negedge clk);
    hcfg_wr = 1'b0; hcfg_wdata = 1'b0;
  endtask

  task automatic strobe(input int which);
    case (which)
      0: pm_req = 1'b1;
      1: p1_ctl = 1'b1;
      2: p2_ctl = 1'b1;
      default: vp_ctl = 1'b1;
    endcase
    @(negedge clk);
    pm_req = 1'b0; p1_ctl = 1'b0; p2_ctl = 1'b0; vp_ctl = 1'b0;
  endtask

  initial begin
    // R1: reset state and release timing
    cyc(4);
    chk("R1 all outputs in power-on reset", 32'(outs), 32'hFF);
    por_n = 1'b1;
    cyc(1);
    chk("R1 still held after first edge", 32'(outs), 32'hFF);
    cyc(1);
    chk("R1 released after second edge", 32'(outs), 32'h00);
    cyc(2);

    // R2: digital reset
    rctl_write(4'b0001);
    chk("R2 digital coverage", 32'(outs), 32'b11111000);
    chk("R7 digital readback", 32'(rctl_rd), 32'b0001);
    cyc(TB_LEN - 1);
    chk("R2 digital last cycle", 32'(outs), 32'b11111000);
    cyc(1);
    chk("R2 digital ended", 32'(outs), 32'h00);
    chk("R7 digital readback cleared", 32'(rctl_rd), 32'b0000);
    cyc(2);

    // R3 and R9: soft reset, rewrite and power-management strobe ignored
    hcfg_write();
    chk("R3 soft coverage", 32'(outs), 32'b11100000);
    chk("R7 soft readback", 32'(soft_rd), 32'd1);
    hcfg_write();
    strobe(0);
    chk("R9 power strobe ignored in lower reset", 32'(vp), 32'd0);
    cyc(TB_LEN - 3);
    chk("R3 soft last cycle", 32'(outs), 32'b11100000);
    cyc(1);
    chk("R9 soft rewrite did not extend", 32'(outs), 32'h00);
    cyc(2);

    // R4, R8, R9: PHY 1 pulse, own strobe ignored, control write reloads
    rctl_write(4'b0010);
    chk("R4 phy1 only", 32'(outs), 32'b00000100);
    cyc(2);
    strobe(1);
    rctl_write(4'b0010);
    cyc(TB_LEN - 1);
    chk("R8 phy1 reloaded", 32'(outs), 32'b00000100);
    cyc(1);
    chk("R8 phy1 ends after reload", 32'(outs), 32'h00);
    strobe(1);
    chk("R4 phy1 via control strobe", 32'(outs), 32'b00000100);
    cyc(TB_LEN + 1);

    // R5
    strobe(2);
    chk("R5 phy2 via control strobe", 32'(outs), 32'b00000010);
    cyc(TB_LEN + 1);
    rctl_write(4'b0100);
    chk("R5 phy2 via control write", 32'(outs), 32'b00000010);
    chk("R7 phy2 readback", 32'(rctl_rd), 32'b0100);
    cyc(TB_LEN + 1);

    // R6: three virtual PHY sources
    rctl_write(4'b1000);
    chk("R6 vphy via control write", 32'(outs), 32'b00000001);
    chk("R7 vphy readback", 32'(rctl_rd), 32'b1000);
    cyc(TB_LEN + 1);
    strobe(0);
    chk("R6 vphy via power strobe", 32'(outs), 32'b00000001);
    cyc(TB_LEN + 1);
    strobe(3);
    chk("R6 vphy via control strobe", 32'(outs), 32'b00000001);
    cyc(TB_LEN + 1);

    // R10 and R9: overlap, writes during digital reset ignored
    rctl_write(4'b0011);
    chk("R10 digital plus phy1", 32'(outs), 32'b11111100);
    rctl_write(4'b0100);
    chk("R9 control write ignored in upper reset", 32'(p2), 32'd0);
    hcfg_write();
    cyc(TB_LEN);
    chk("R9 soft not started during digital", 32'(soft_rd), 32'd0);
    cyc(2);

    // R10: soft then digital, staggered end
    hcfg_write();
    cyc(2);
    rctl_write(4'b0001);
    cyc(TB_LEN - 1);
    chk("R10 soft ended first", 32'(soft_rd), 32'd0);
    chk("R10 lower domains held by digital", 32'(outs), 32'b11111000);
    cyc(1);
    chk("R10 all clear", 32'(outs), 32'h00);
    cyc(2);

    // R1: external pin mid-pulse
    rctl_write(4'b0010);
    ext_n = 1'b0;
    #1;
    chk("R1 external pin asserts at once", 32'(outs), 32'hFF);
    cyc(3);
    ext_n = 1'b1;
    cyc(2);
    chk("R1 pulse cleared by chip reset", 32'(outs), 32'h00);
    chk("R1 readback cleared by chip reset", 32'(rctl_rd), 32'b0000);
    cyc(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule